// File: doc/BRIEF.md
# VBUS Overvoltage and Undervoltage Supervisor

This block sits between three VBUS comparator outputs (overvoltage, below the undervoltage trip level, at or above the undervoltage release level) and the power-path switch that feeds the system from the receptacle. It enables the switch only after a clean bring-up sequence and only while the connection logic reports a valid attachment. It removes the switch at once whenever an overvoltage or undervoltage flag is raised.

An overvoltage is handled in two tiers. A pulse that lasts no longer than an auto-recovery window, counted in clock cycles, is forgiven: once the flag drops, the supervisor re-runs its detect step and closes the switch again. A pulse that lasts longer latches the switch open. Only an undervoltage event clears that latch. Undervoltage sends the block to its off state, pulses a clear to the connection logic, and holds detection off until VBUS climbs back to the release level. The comparator flags are assumed to be already synchronised to `clk`.

Top module: `vbus_supervisor`

## Requirements
- R1: While `rst` is high, `path_en` is 0 and `conn_clear` is 1. On the first clock edge after reset is released, with `vbus_uv` low, `conn_clear` returns to 0 and `path_en` stays 0.
- R2: In any cycle where `vbus_ov` or `vbus_uv` is 1, `path_en` is 0 in that same cycle.
- R3: After power-off with `vbus_uv` low, the supervisor waits. The edge that samples `vbus_rel`=1 starts detection, and `detect_go` is 1 for the following cycle. Every later edge that samples `conn_ok`=1 during detection sets `path_en` to 1. While `conn_ok` is 0, the switch stays off.
- R4: While `vbus_rel` is 0 in the wait phase, `detect_go` stays 0 and `path_en` stays 0. `detect_go` is never high for two cycles in a row.
- R5: An overvoltage sampled high on N consecutive edges, with 1 <= N <= WIN (WIN = CLK_MHZ*WINDOW_US), does not latch. The second edge after the flag drops sees `path_en` at 1 again, provided `conn_ok` is 1.
- R6: An overvoltage sampled high on WIN+1 or more consecutive edges latches the switch off. `path_en` stays 0 after the flag drops.
- R7: While latched, changes on `vbus_ov`, `vbus_rel` and `conn_ok` have no effect: `path_en` and `detect_go` stay 0. Only `vbus_uv` clears the latch, after which the normal bring-up sequence closes the switch again.
- R8: An edge that samples `vbus_uv`=1 from any state other than off moves the block to off. `conn_clear` is 1 for exactly the next cycle and stays 0 while `vbus_uv` is held.
- R9: When `vbus_uv` and `vbus_ov` are both 1, undervoltage wins. The block goes to off with a `conn_clear` pulse, and no overvoltage latch is left behind, however long the overlap lasts.
- R10: The overvoltage window restarts whenever the flag is sampled low. Two pulses of WIN edges each, separated by one low edge, do not latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vbus_ov | input | 1 | VBUS above overvoltage trip level |
| vbus_uv | input | 1 | VBUS below undervoltage trip level |
| vbus_rel | input | 1 | VBUS at or above undervoltage release level |
| conn_ok | input | 1 | Connection logic reports a valid attachment |
| path_en | output | 1 | Enable for the VBUS power-path switch |
| conn_clear | output | 1 | One-cycle clear for the connection logic |
| detect_go | output | 1 | One-cycle start of connection detection |

## Verification
The bench sweeps the overvoltage pulse length across every value from one edge to twice the window. This catches an off-by-one in the recovery counter, which would either latch a pulse of exactly WIN edges or forgive one of WIN+1. Once the switch is latched, it toggles the release flag, connection status and further overvoltage pulses, so a design that let any of these reopen the switch is exposed. It holds undervoltage and overvoltage together for longer than the window; a design with the wrong priority would stay latched after both clear. It also splits a long overvoltage with a single low edge to check that a counter which fails to restart is caught.

// File: rtl/vsup_pkg.sv
package vsup_pkg;

    typedef enum logic [2:0] {
        ST_POWER_OFF    = 3'd0,
        ST_WAIT_RELEASE = 3'd1,
        ST_DETECT       = 3'd2,
        ST_ON           = 3'd3,
        ST_OV_TRANSIENT = 3'd4,
        ST_OV_LATCHED   = 3'd5
    } vsup_state_e;

    typedef struct packed {
        logic ov;
        logic uv;
        logic rel;
        logic conn;
    } vsup_flags_t;

    typedef struct packed {
        logic clr;
        logic det;
    } vsup_pulse_t;

    // recovery window length in cycles, never below one
    function automatic int win_cycles(input int mhz, input int us);
        int w;
        w = mhz * us;
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/vsup_ov_timer.sv
module vsup_ov_timer #(
    parameter int WIN = 10,
    localparam int CW = $clog2(WIN + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);
    logic [CW-1:0] cnt;

    assign expire = run && (cnt == CW'(WIN - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (!expire) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/vsup_fsm.sv
module vsup_fsm
    import vsup_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  vsup_flags_t fl,
    input  logic        expire,
    output vsup_state_e st,
    output vsup_state_e nxt
);
    always_comb begin
        nxt = st;
        if (fl.uv) begin
            nxt = ST_POWER_OFF;
        end else begin
            unique case (st)
                ST_POWER_OFF:    nxt = ST_WAIT_RELEASE;
                ST_WAIT_RELEASE: if (fl.rel) nxt = ST_DETECT;
                ST_DETECT: begin
                    if (fl.ov)        nxt = ST_OV_TRANSIENT;
                    else if (fl.conn) nxt = ST_ON;
                end
                ST_ON:           if (fl.ov) nxt = ST_OV_TRANSIENT;
                ST_OV_TRANSIENT: begin
                    if (!fl.ov)      nxt = ST_DETECT;
                    else if (expire) nxt = ST_OV_LATCHED;
                end
                ST_OV_LATCHED:   nxt = ST_OV_LATCHED;
                default:         nxt = ST_POWER_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_POWER_OFF;
        else     st <= nxt;
    end
endmodule

// File: rtl/vsup_pulse.sv
module vsup_pulse
    import vsup_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  vsup_state_e st,
    input  vsup_state_e nxt,
    output vsup_pulse_t pq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pq.clr <= 1'b1;
            pq.det <= 1'b0;
        end else begin
            pq.clr <= (nxt == ST_POWER_OFF) && (st != ST_POWER_OFF);
            pq.det <= (st == ST_WAIT_RELEASE) && (nxt == ST_DETECT);
        end
    end
endmodule

// File: rtl/vbus_supervisor.sv
module vbus_supervisor
    import vsup_pkg::*;
#(
    parameter int CLK_MHZ   = 100,
    parameter int WINDOW_US = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic vbus_ov,
    input  logic vbus_uv,
    input  logic vbus_rel,
    input  logic conn_ok,
    output logic path_en,
    output logic conn_clear,
    output logic detect_go
);
    localparam int WIN = win_cycles(CLK_MHZ, WINDOW_US);

    vsup_flags_t fl;
    vsup_state_e st;
    vsup_state_e nxt;
    vsup_pulse_t pq;
    logic        ov_run;
    logic        ov_expire;

    assign fl     = '{ov: vbus_ov, uv: vbus_uv, rel: vbus_rel, conn: conn_ok};
    assign ov_run = (st == ST_OV_TRANSIENT) && fl.ov && !fl.uv;

    vsup_ov_timer #(.WIN(WIN)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (ov_run),
        .expire (ov_expire)
    );

    vsup_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .fl     (fl),
        .expire (ov_expire),
        .st     (st),
        .nxt    (nxt)
    );

    vsup_pulse u_pulse (
        .clk (clk),
        .rst (rst),
        .st  (st),
        .nxt (nxt),
        .pq  (pq)
    );

    assign path_en    = (st == ST_ON) && !fl.ov && !fl.uv;
    assign conn_clear = pq.clr;
    assign detect_go  = pq.det;
endmodule

// File: rtl/vbus_supervisor_chk.sv
module vbus_supervisor_chk
    import vsup_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        vbus_ov,
    input logic        vbus_uv,
    input logic        path_en,
    input logic        conn_clear,
    input logic        detect_go,
    input vsup_state_e st
);
    assert_off_on_ov_R2: assert property (@(posedge clk) disable iff (rst)
        vbus_ov |-> !path_en);

    assert_off_on_uv_R2: assert property (@(posedge clk) disable iff (rst)
        vbus_uv |-> !path_en);

    assert_detect_single_R4: assert property (@(posedge clk) disable iff (rst)
        detect_go |=> !detect_go);

    assert_short_recover_R5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_OV_TRANSIENT && !vbus_ov && !vbus_uv) |=> (st == ST_DETECT));

    assert_latch_needs_ov_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(st == ST_OV_LATCHED) |-> $past(vbus_ov));

    assert_latch_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_OV_LATCHED && !vbus_uv) |=> (st == ST_OV_LATCHED && !path_en));

    assert_uv_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (vbus_uv && st != ST_POWER_OFF) |=> (conn_clear && st == ST_POWER_OFF));

    assert_clear_single_R8: assert property (@(posedge clk) disable iff (rst)
        conn_clear |=> !conn_clear);
endmodule

bind vbus_supervisor vbus_supervisor_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .vbus_ov    (vbus_ov),
    .vbus_uv    (vbus_uv),
    .path_en    (path_en),
    .conn_clear (conn_clear),
    .detect_go  (detect_go),
    .st         (st)
);

// File: tb/tb_vbus_supervisor.sv
module tb_vbus_supervisor;
    localparam int T   = 10;
    localparam int WIN = 4;

    logic clk = 1'b0;
    logic rst, vbus_ov, vbus_uv, vbus_rel, conn_ok;
    logic path_en, conn_clear, detect_go;
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 0;

    always #(T/2) clk = ~clk;

    vbus_supervisor #(.CLK_MHZ(1), .WINDOW_US(WIN)) dut (
        .clk(clk), .rst(rst), .vbus_ov(vbus_ov), .vbus_uv(vbus_uv),
        .vbus_rel(vbus_rel), .conn_ok(conn_ok), .path_en(path_en),
        .conn_clear(conn_clear), .detect_go(detect_go)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // off -> wait -> detect -> on with rel and conn_ok high
    task automatic bring_up(input string req);
        vbus_uv = 0; vbus_rel = 1; conn_ok = 1;
        tick(); tick(); tick();
        chk(req, path_en, 1'b1);
    endtask

    task automatic uv_reset(input string req);
        vbus_uv = 1;
        tick();
        chk("R8 clear pulse", conn_clear, 1'b1);
        chk("R8 path off", path_en, 1'b0);
        tick();
        chk("R8 clear single", conn_clear, 1'b0);
        bring_up(req);
    endtask

    initial begin
        rst = 1; vbus_ov = 0; vbus_uv = 0; vbus_rel = 0; conn_ok = 0;
        tick();
        chk("R1 reset path", path_en, 1'b0);
        chk("R1 reset clear", conn_clear, 1'b1);
        rst = 0;
        tick();
        chk("R1 clear low", conn_clear, 1'b0);
        chk("R1 path low", path_en, 1'b0);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R4 no detect while rel low", detect_go, 1'b0);
            chk("R4 path off in wait", path_en, 1'b0);
        end
        vbus_rel = 1;
        tick();
        chk("R3 detect pulse", detect_go, 1'b1);
        tick();
        chk("R4 detect single", detect_go, 1'b0);
        chk("R3 off without conn", path_en, 1'b0);
        conn_ok = 1;
        tick();
        chk("R3 switch on", path_en, 1'b1);

        for (int n = 1; n <= 2*WIN; n++) begin
            vbus_ov = 1;
            #1;
            chk("R2 off on ov", path_en, 1'b0);
            for (int k = 0; k < n; k++) tick();
            vbus_ov = 0;
            tick(); tick();
            if (n <= WIN) begin
                chk("R5 short pulse recovers", path_en, 1'b1);
            end else begin
                chk("R6 long pulse latches", path_en, 1'b0);
                vbus_rel = 0; conn_ok = 0;
                tick(); tick();
                vbus_rel = 1; conn_ok = 1; vbus_ov = 1;
                tick();
                vbus_ov = 0;
                for (int k = 0; k < 4; k++) begin
                    tick();
                    chk("R7 latch holds path", path_en, 1'b0);
                    chk("R7 latch no detect", detect_go, 1'b0);
                end
                uv_reset("R7 restart after uv");
            end
        end

        // R10: split overvoltage
        vbus_ov = 1;
        for (int k = 0; k < WIN; k++) tick();
        vbus_ov = 0;
        tick();
        vbus_ov = 1;
        for (int k = 0; k < WIN; k++) tick();
        vbus_ov = 0;
        tick(); tick();
        chk("R10 window restarts", path_en, 1'b1);

        // R9: uv and ov overlap
        vbus_ov = 1; vbus_uv = 1;
        #1;
        chk("R2 off on both", path_en, 1'b0);
        tick();
        chk("R9 uv priority clear", conn_clear, 1'b1);
        for (int k = 0; k < 2*WIN; k++) begin
            tick();
            chk("R9 no repeat clear", conn_clear, 1'b0);
        end
        vbus_ov = 0;
        bring_up("R9 no latch left");

        // R8 from detect state
        conn_ok = 0; vbus_uv = 1;
        tick(); tick();
        vbus_uv = 0;
        tick(); tick();
        chk("R3 detect pulse again", detect_go, 1'b1);
        vbus_uv = 1;
        tick();
        chk("R8 clear from detect", conn_clear, 1'b1);
        vbus_uv = 0;
        bring_up("R3 resume");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(T*100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule